// File: doc/BRIEF.md
# I2C Bus State Monitor

This block follows the two wires of an I2C bus as seen by a host controller and keeps a two-bit view of who holds the bus. The view can be unknown, idle, held by this host, or held by some other master. Each wire passes through a synchronizer, and the block then looks for edges. SDA falling while SCL is high marks a Start. SDA rising while SCL is high marks a Stop. A Start takes the bus either for this host or for a foreign master, depending on a side-band flag from the host's own sequencer. A Stop releases the bus.

The block also guards the bus protocol. A Stop that arrives with no SCL clock pulse since the most recent Start or repeated Start is illegal. While the host is enabled, such a Stop produces a single-cycle error pulse. Software can put the view back to idle by writing the idle code. Any other written code is dropped. When the host's arbitration logic reports a lost arbitration, the view moves from held-by-this-host to held-by-another. The system clock must run at four or more times the SCL rate, so that every line level lasts several samples.

Top module: `i2c_bus_monitor`

## Requirements
- R1: `busState` uses the codes 0 = unknown, 1 = idle, 2 = held by this host, 3 = held by another master. While reset is asserted, and after it is released, the state is 0 and `busErr` is 0.
- R2: A Start (SDA falls while SCL stays high) sets the state to 2 if `selfStart` is 1 in the detection cycle, and to 3 if it is 0. A repeated Start follows the same rule.
- R3: A Stop (SDA rises while SCL stays high) sets the state to 1.
- R4: A cycle with `stateWr` = 1 and `stateWrData` = 1 sets the state to 1 on the next clock. With `stateWrData` equal to 0, 2 or 3, the write leaves the state unchanged.
- R5: If a force-to-idle write and a detected Start or Stop fall in the same cycle, the write wins and the state becomes 1. A write of any other code does not block the line event.
- R6: `arbLost` moves the state from 2 to 3 when no line event is detected in that cycle. In states 0, 1 and 3 it has no effect.
- R7: While `enable` is 1, a Stop with no SCL rising edge since the last Start or repeated Start raises `busErr` for exactly one clock cycle.
- R8: While `enable` is 0, `busErr` stays 0 in every case.
- R9: A Stop after at least one SCL rising edge since the last Start raises no error. A repeated Start clears this count, so a repeated Start directly followed by a Stop is an error.
- R10: A change on `sclIn` or `sdaIn` reaches `busState` and `busErr` on the third rising clock edge after the change. The first two edges do not yet show it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Host enable; gates bus error detection |
| sclIn | input | 1 | Raw SCL line sample |
| sdaIn | input | 1 | Raw SDA line sample |
| selfStart | input | 1 | This host is the one issuing the current Start |
| arbLost | input | 1 | Arbitration-lost event from the host |
| stateWr | input | 1 | Software write strobe for the state field |
| stateWrData | input | 2 | Value written to the state field |
| busState | output | 2 | Current bus state code |
| busErr | output | 1 | One-cycle bus error pulse |

## Verification
Two things can land in the same cycle: a software write to the state field and a Start detected on the lines. The bench lowers SDA, counts two clock edges so that the Start falls into the detection cycle, and places the write strobe in exactly that cycle. With the idle code written, the bench expects idle. With a non-idle code written, it expects the state the Start alone would give. Because an off-by-one slip in the write timing would leave either outcome unexplained, the cycle placement is also checked separately by sampling the state after edges one, two and three.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    BUS_UNKNOWN = 2'd0,
    BUS_IDLE    = 2'd1,
    BUS_OWNER   = 2'd2,
    BUS_BUSY    = 2'd3
  } busState_t;

  // Strobes handed from the line datapath to the state control.
  typedef struct packed {
    logic start;     // Start or repeated Start seen this cycle
    logic stop;      // Stop seen this cycle
    logic bareStop;  // Stop with no SCL clock since the last Start
  } lineEvents_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  // Idle I2C lines are high, so the chain resets to ones and no edge
  // appears when reset is released.
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

  initial begin
    a_r10_min_stages: assert (STAGES >= 2);
  end

endmodule

// File: rtl/i2cmon_datapath.sv
module i2cmon_datapath
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output lineEvents_t events
);

  localparam int LINES  = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;

  assign rawLines[SCL_IX] = sclIn;
  assign rawLines[SDA_IX] = sdaIn;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_sync
      i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rstN (rstN),
        .din  (rawLines[i]),
        .dout (syncLines[i])
      );
    end
  endgenerate

  logic sclNow, sdaNow;
  logic sclPrev, sdaPrev;

  assign sclNow = syncLines[SCL_IX];
  assign sdaNow = syncLines[SDA_IX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  logic sclHigh, startEdge, stopEdge, sclRise;

  assign sclHigh   = sclNow & sclPrev;
  assign startEdge = sclHigh & sdaPrev & ~sdaNow;
  assign stopEdge  = sclHigh & ~sdaPrev & sdaNow;
  assign sclRise   = ~sclPrev & sclNow;

  // Frame tracking: inFrame is set between a Start and a Stop, and
  // bitSeen records that SCL has clocked since the last (repeated) Start.
  logic inFrame, bitSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitSeen <= 1'b0;
    end else if (startEdge) begin
      inFrame <= 1'b1;
      bitSeen <= 1'b0;
    end else if (stopEdge) begin
      inFrame <= 1'b0;
      bitSeen <= 1'b0;
    end else if (sclRise && inFrame) begin
      bitSeen <= 1'b1;
    end
  end

  assign events.start    = startEdge;
  assign events.stop     = stopEdge;
  assign events.bareStop = stopEdge & inFrame & ~bitSeen;

  // R9: a repeated Start always opens a clean frame.
  a_r9_start_opens_frame: assert property (@(posedge clk) disable iff (!rstN)
    events.start |=> (inFrame && !bitSeen));

  // R7: the cycle right after a Start cannot hold a bare Stop.
  a_r7_no_instant_stop: assert property (@(posedge clk) disable iff (!rstN)
    events.start |=> !events.bareStop);

endmodule

// File: rtl/i2cmon_control.sv
module i2cmon_control
  import i2cmon_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               selfStart,
  input  logic               arbLost,
  input  logic               stateWr,
  input  logic [STATE_W-1:0] stateWrData,
  input  lineEvents_t        events,
  output logic [STATE_W-1:0] busState,
  output logic               busErr
);

  busState_t stateQ, stateNext;
  logic      forceIdle;

  assign forceIdle = stateWr && (stateWrData == STATE_W'(BUS_IDLE));

  always_comb begin
    stateNext = stateQ;
    if (forceIdle) begin
      stateNext = BUS_IDLE;
    end else if (events.start) begin
      stateNext = selfStart ? BUS_OWNER : BUS_BUSY;
    end else if (events.stop) begin
      stateNext = BUS_IDLE;
    end else if (arbLost && stateQ == BUS_OWNER) begin
      stateNext = BUS_BUSY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= BUS_UNKNOWN;
      busErr <= 1'b0;
    end else begin
      stateQ <= stateNext;
      busErr <= enable & events.bareStop;
    end
  end

  assign busState = stateQ;

  // R1: reset leaves the unknown code and a quiet error line.
  a_r1_reset_unknown: assert property (@(posedge clk)
    !rstN |=> (busState == 2'd0 && !busErr));

  // R4: the idle code always lands.
  a_r4_force_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stateWr && stateWrData == 2'd1) |=> busState == 2'd1);

  // R2: a Start without a competing write picks owner or busy.
  a_r2_start_owner: assert property (@(posedge clk) disable iff (!rstN)
    (events.start && !(stateWr && stateWrData == 2'd1))
      |=> busState == ($past(selfStart) ? 2'd2 : 2'd3));

  // R6: arbitration loss while owning hands the bus to another master.
  a_r6_arb_to_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busState == 2'd2 && arbLost && !stateWr && !events.start && !events.stop)
      |=> busState == 2'd3);

  // R8: no error pulse follows a disabled cycle.
  a_r8_err_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busErr);

  // R7: the error is a single-cycle pulse.
  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       selfStart,
  input  logic       arbLost,
  input  logic       stateWr,
  input  logic [1:0] stateWrData,
  output logic [1:0] busState,
  output logic       busErr
);

  lineEvents_t events;

  i2cmon_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .events (events)
  );

  i2cmon_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .selfStart   (selfStart),
    .arbLost     (arbLost),
    .stateWr     (stateWr),
    .stateWrData (stateWrData),
    .events      (events),
    .busState    (busState),
    .busErr      (busErr)
  );

endmodule

// File: tb/sim_i2c_bus_monitor.sv
`timescale 1ns/1ps
module sim_i2c_bus_monitor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic       selfStart = 1'b0;
  logic       arbLost = 1'b0;
  logic       stateWr = 1'b0;
  logic [1:0] stateWrData = 2'd0;
  logic [1:0] busState;
  logic       busErr;

  int total = 0;
  int bad = 0;
  int errPulses = 0;

  always #2 clk = ~clk;

  i2c_bus_monitor u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn), .sdaIn(sdaIn),
    .selfStart(selfStart), .arbLost(arbLost), .stateWr(stateWr),
    .stateWrData(stateWrData), .busState(busState), .busErr(busErr)
  );

  always @(negedge clk) if (rstN && busErr) errPulses++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lines(input logic s, input logic d);
    @(negedge clk);
    sclIn = s;
    sdaIn = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sclIn = 1'b1; sdaIn = 1'b1; selfStart = 1'b0;
    arbLost = 1'b0; stateWr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doStart(input logic self);
    selfStart = self;
    lines(1'b1, 1'b0);
    selfStart = 1'b0;
  endtask

  task automatic doBit();
    lines(1'b0, sdaIn);
    lines(1'b1, sdaIn);
  endtask

  task automatic doStopFull();
    lines(1'b0, sdaIn);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
  endtask

  task automatic forceWrite(input logic [1:0] d);
    @(negedge clk);
    stateWr = 1'b1; stateWrData = d;
    @(negedge clk);
    stateWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic reach(input int st);
    doReset();
    case (st)
      1: forceWrite(2'd1);
      2: doStart(1'b1);
      3: doStart(1'b0);
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0;
    // R1: reset state
    @(negedge clk);
    chk("R1 state in reset", busState, 0);
    doReset();
    chk("R1 state after reset", busState, 0);
    chk("R1 error after reset", busErr, 0);

    // R2 R3 R7 R8 R9: sweep enable, issuer and bit count
    for (int en = 0; en < 2; en++)
      for (int self = 0; self < 2; self++)
        for (int nb = 0; nb < 3; nb++) begin
          doReset();
          enable = en[0];
          forceWrite(2'd1);
          doStart(self[0]);
          chk("R2 start state", busState, self ? 2 : 3);
          e0 = errPulses;
          if (nb == 0) lines(1'b1, 1'b1);
          else begin
            for (int b = 0; b < nb; b++) doBit();
            doStopFull();
          end
          chk("R3 stop state", busState, 1);
          chk(en ? (nb == 0 ? "R7 bare stop pulse" : "R9 clocked stop quiet")
                 : "R8 disabled quiet",
              errPulses - e0, (en && nb == 0) ? 1 : 0);
        end

    // R9: repeated Start resets the bit count
    doReset(); enable = 1'b1;
    doStart(1'b1); doBit();
    lines(1'b0, 1'b1); lines(1'b1, 1'b1);
    e0 = errPulses;
    doStart(1'b0);
    chk("R2 repeated start state", busState, 3);
    lines(1'b1, 1'b1);
    chk("R9 bare stop after repeated start", errPulses - e0, 1);
    chk("R3 stop after repeated start", busState, 1);

    // R4: every write code from every state
    for (int st = 0; st < 4; st++)
      for (int wd = 0; wd < 4; wd++) begin
        reach(st);
        forceWrite(wd[1:0]);
        chk("R4 state write", busState, (wd == 1) ? 1 : st);
      end

    // R6: arbitration loss in every state
    for (int st = 0; st < 4; st++) begin
      reach(st);
      @(negedge clk); arbLost = 1'b1;
      @(negedge clk); arbLost = 1'b0;
      @(negedge clk);
      chk("R6 arbitration loss", busState, (st == 2) ? 3 : st);
    end

    // R5 and R10: write and Start in one cycle; edge counting
    for (int wd = 1; wd < 3; wd++) begin
      doReset(); enable = 1'b1;
      forceWrite(2'd1);
      @(negedge clk); sdaIn = 1'b0;
      @(negedge clk);
      chk("R10 after one edge", busState, 1);
      @(negedge clk);
      chk("R10 after two edges", busState, 1);
      stateWr = 1'b1; stateWrData = wd[1:0];
      @(negedge clk);
      stateWr = 1'b0;
      chk("R5 write against start", busState, (wd == 1) ? 1 : 3);
      repeat (3) @(negedge clk);
    end

    // R10: Stop reaches the state on the third edge
    doReset(); forceWrite(2'd1); doStart(1'b0);
    @(negedge clk); sdaIn = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 stop after two edges", busState, 3);
    @(negedge clk);
    chk("R10 stop after three edges", busState, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule